// File: doc/BRIEF.md
# Release-Phased Clock Divider

This block derives a slower system clock from a fast edge clock by dividing it by 2, 4 or 8. A two-bit ratio select is captured while reset is held. After reset the divided output is kept low. It starts only when a separate start strobe is seen high on a rising edge of the fast clock. The edge on which the strobe is sampled sets the phase of the slow clock against the fast clock.

Several copies that share the fast clock, the reset, the start strobe and the ratio select therefore produce the same waveform on every cycle. A sticky status output tells downstream logic that the divided clock is toggling.

Top module: `clkdiv_aligned`

## Requirements
- R1: The ratio select `mode_i` gives the division ratio N as follows: 2'b00 gives N=2, 2'b01 gives N=4, 2'b10 gives N=8, and 2'b11 also gives N=8.
- R2: Reset is synchronous and active high. After any fast-clock edge with `rst` high, `clk_div` and `running` are low.
- R3: After reset, `clk_div` stays low on every edge where `release_i` is sampled low, however many such edges pass.
- R4: On the first edge after reset where `release_i` is sampled high, the divide count restarts at zero and `clk_div` goes high on that same edge.
- R5: Counting from the start edge as edge 0, `clk_div` after edge j is high when (j mod N) < N/2 and low otherwise. This gives a 50% duty cycle that begins with the high half.
- R6: `mode_i` is captured on every edge with `rst` high, and the value on the last such edge is the one used. Changes to `mode_i` while reset is low do not alter the ratio.
- R7: When `rst` and `release_i` are both high on the same edge, reset wins: `clk_div` and `running` stay low.
- R8: Once started, `release_i` falling or toggling has no effect on `clk_div` or `running`. Only a reset stops the divider.
- R9: `running` rises on the start edge, together with the first rise of `clk_div`, and stays high until the next reset.
- R10: Two instances driven by identical inputs produce identical `clk_div` and `running` after every edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast source clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset; also the ratio capture window |
| release_i | input | 1 | Start strobe, sampled on the fast clock |
| mode_i | input | 2 | Division ratio select |
| clk_div | output | 1 | Divided clock, registered |
| running | output | 1 | High while the divider is toggling |

## Verification
A wrong count value shows at `clk_div` within one slow period: the high or low phase has the wrong length, or an edge falls on the wrong fast cycle. A start flag that is not set correctly shows in one of two ways. Either `running` and the first rise of `clk_div` come one cycle early or late, or a dropped `release_i` stops the output. A ratio latch that takes `mode_i` outside reset changes the period at the next wrap, and the bench checks this against the formula in R5. Comparing two instances edge by edge catches any state that reset does not define.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int MODE_W  = 2;
  localparam int MAX_DIV = 8;
  localparam int CNT_W   = $clog2(MAX_DIV);

  // Half of the division ratio for a given select code (R1).
  function automatic logic [CNT_W-1:0] half_of(input logic [MODE_W-1:0] m);
    case (m)
      2'b00:   half_of = CNT_W'(1);
      2'b01:   half_of = CNT_W'(2);
      default: half_of = CNT_W'(4);
    endcase
  endfunction

  // Last count value of one slow period: N - 1.
  function automatic logic [CNT_W-1:0] last_of(input logic [MODE_W-1:0] m);
    last_of = CNT_W'((2 * int'(half_of(m))) - 1);
  endfunction
endpackage

// File: rtl/clkdiv_mode_latch.sv
module clkdiv_mode_latch
  import clkdiv_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [MODE_W-1:0] mode_i,
  output logic [CNT_W-1:0]  half_o,
  output logic [CNT_W-1:0]  last_o
);
  logic [MODE_W-1:0] mode_q;

  always_ff @(posedge clk) begin
    if (rst) mode_q <= mode_i;
  end

  assign half_o = half_of(mode_q);
  assign last_o = last_of(mode_q);

  // R6: the captured ratio holds while out of reset
  p_mode_hold_r6: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(mode_q));
endmodule

// File: rtl/clkdiv_start_ctl.sv
module clkdiv_start_ctl (
  input  logic clk,
  input  logic rst,
  input  logic release_i,
  output logic start_o,
  output logic active_o
);
  logic started_q;

  // Start event: first sampled release after reset (reset wins, R7).
  assign start_o  = !rst && !started_q && release_i;
  assign active_o = started_q;

  always_ff @(posedge clk) begin
    if (rst)          started_q <= 1'b0;
    else if (start_o) started_q <= 1'b1;
  end

  // R8/R9: once active, only reset clears it
  p_run_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    started_q |=> started_q);
endmodule

// File: rtl/clkdiv_counter.sv
module clkdiv_counter
  import clkdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             active_i,
  input  logic [CNT_W-1:0] half_i,
  input  logic [CNT_W-1:0] last_i,
  output logic             div_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic             cnt_wrap;
  logic             half_point;

  assign cnt_wrap   = active_i && (cnt_q == last_i);
  assign half_point = active_i && (cnt_q == half_i - 1'b1);
  assign cnt_nxt    = cnt_wrap ? '0 : cnt_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      div_o <= 1'b0;
    end else if (start_i) begin
      cnt_q <= '0;
      div_o <= 1'b1;
    end else if (active_i) begin
      cnt_q <= cnt_nxt;
      div_o <= (cnt_nxt < half_i);
    end
  end

  // R5: a new period begins with the high half
  p_rise_after_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    cnt_wrap |=> div_o);
  // R5: the output drops after N/2 high cycles
  p_fall_at_half_r5: assert property (@(posedge clk) disable iff (rst)
    half_point |=> !div_o);
  // R4: the start edge raises the output
  p_start_high_r4: assert property (@(posedge clk) disable iff (rst)
    start_i |=> div_o);
  // R3: held low until started
  p_hold_low_r3: assert property (@(posedge clk) disable iff (rst)
    (!active_i && !start_i) |=> !div_o);
endmodule

// File: rtl/clkdiv_aligned.sv
module clkdiv_aligned
  import clkdiv_pkg::*;
(
  input  logic              clk_fast,
  input  logic              rst,
  input  logic              release_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic              clk_div,
  output logic              running
);
  logic [CNT_W-1:0] half_w;
  logic [CNT_W-1:0] last_w;
  logic             start_w;
  logic             active_w;
  logic             seen_q;

  clkdiv_mode_latch u_mode (
    .clk(clk_fast), .rst(rst), .mode_i(mode_i),
    .half_o(half_w), .last_o(last_w)
  );

  clkdiv_start_ctl u_start (
    .clk(clk_fast), .rst(rst), .release_i(release_i),
    .start_o(start_w), .active_o(active_w)
  );

  clkdiv_counter u_cnt (
    .clk(clk_fast), .rst(rst), .start_i(start_w), .active_i(active_w),
    .half_i(half_w), .last_i(last_w), .div_o(clk_div)
  );

  assign running = active_w;

  always_ff @(posedge clk_fast) seen_q <= 1'b1;

  // R2/R7: reset forces both outputs low after the edge
  p_reset_low_r2: assert property (@(posedge clk_fast) disable iff (seen_q !== 1'b1)
    rst |=> (!clk_div && !running));
  // R9: running rises together with the first divided edge
  p_run_with_rise_r9: assert property (@(posedge clk_fast) disable iff (rst)
    $rose(running) |-> clk_div);
endmodule

// File: tb/clkdiv_aligned_bench.sv
module clkdiv_aligned_bench;
  logic       clk_fast = 1'b0;
  logic       rst = 1'b1;
  logic       release_i = 1'b0;
  logic [1:0] mode_i = 2'b00;
  logic       clk_div, running, twin_div, twin_run;
  int         checks = 0;
  int         errors = 0;
  bit         done = 1'b0;

  always #10 clk_fast = ~clk_fast;

  clkdiv_aligned u_clkdiv_aligned (
    .clk_fast(clk_fast), .rst(rst), .release_i(release_i), .mode_i(mode_i),
    .clk_div(clk_div), .running(running)
  );

  clkdiv_aligned u_twin (
    .clk_fast(clk_fast), .rst(rst), .release_i(release_i), .mode_i(mode_i),
    .clk_div(twin_div), .running(twin_run)
  );

  // Vector table: ratio code, expected ratio, idle edges before release.
  localparam int NV = 5;
  localparam logic [1:0] V_MODE [NV] = '{2'b00, 2'b01, 2'b10, 2'b11, 2'b01};
  localparam int         V_N    [NV] = '{2, 4, 8, 8, 4};
  localparam int         V_HOLD [NV] = '{0, 3, 1, 5, 2};

  task automatic tick();
    @(posedge clk_fast);
    @(negedge clk_fast);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic model(input int j, input int n);
    return ((j % n) < (n / 2));
  endfunction

  // R10: both copies agree after every edge
  task automatic chk_twin();
    chk("R10 div", twin_div, clk_div);
    chk("R10 run", twin_run, running);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk_fast);
    for (int v = 0; v < NV; v++) begin
      rst = 1'b1; release_i = 1'b0; mode_i = V_MODE[v];
      tick();
      chk("R2 div", clk_div, 1'b0);
      chk("R2 run", running, 1'b0);
      rst = 1'b0;
      for (int h = 0; h < V_HOLD[v]; h++) begin
        tick();
        chk("R3 held", clk_div, 1'b0);
        chk("R9 idle", running, 1'b0);
      end
      release_i = 1'b1;
      tick();
      chk("R4 first", clk_div, 1'b1);
      chk("R9 rise", running, 1'b1);
      for (int j = 1; j < 3 * V_N[v]; j++) begin
        if (j == V_N[v]) begin
          mode_i = ~V_MODE[v];      // R6: ignored while running
          release_i = 1'b0;         // R8: ignored once started
        end
        tick();
        chk("R1/R5/R6/R8 div", clk_div, model(j, V_N[v]));
        chk("R9 run", running, 1'b1);
        chk_twin();
      end
      release_i = 1'b1;
    end

    // R7: reset and release together
    rst = 1'b1; release_i = 1'b1; mode_i = 2'b01;
    tick();
    tick();
    chk("R7 div", clk_div, 1'b0);
    chk("R7 run", running, 1'b0);

    // R6: the last reset cycle's select wins (2'b10 gives N=8)
    release_i = 1'b0; mode_i = 2'b00;
    tick();
    mode_i = 2'b10;
    tick();
    rst = 1'b0; release_i = 1'b1; mode_i = 2'b00;
    tick();
    chk("R4 restart", clk_div, 1'b1);
    for (int j = 1; j < 16; j++) begin
      release_i = j[0];
      tick();
      chk("R6 last capture", clk_div, model(j, 8));
      chk_twin();
    end

    // R2: reset in mid-run returns to held-low
    rst = 1'b1;
    tick();
    chk("R2 midrun div", clk_div, 1'b0);
    chk("R2 midrun run", running, 1'b0);
    rst = 1'b0; release_i = 1'b0;
    tick();
    tick();
    chk("R3 after midrun", clk_div, 1'b0);
    chk_twin();

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule